// File: doc/BRIEF.md
# Evolutionary Configuration Search Engine

This block runs a generational evolutionary search for a configuration word that makes a reconfigurable fabric reproduce a target behaviour. Each candidate configuration (a chromosome of `CW` bits, one bit per fabric configuration bit) leaves the engine on a valid/ready stream towards an external scorer. The scorer returns one fitness value per candidate on a second valid/ready stream. Only one candidate is in flight at a time. The engine does not accept a new score until it has offered a candidate, and it does not offer the next candidate until the score for the current one has arrived.

After `start`, the engine builds generation zero. It fills this generation with random chromosomes from an internal 32-bit LFSR, or, in seed mode, from a supplied chromosome and single-bit mutants of it. While the scores arrive, the engine keeps the `NPAR` best chromosomes of the generation in ranked order. These become the parents of the next generation. Slot 0 of that generation is an unmodified copy of the best parent. Every other slot is a one-bit mutant of a parent, with parents taken in rotating order. At each generation boundary, the engine checks three stop conditions. When one of them holds, it raises `done` for one cycle and reports the cause, the best chromosome and fitness found, and the number of generations that ran.

Back-pressure rules: `cand_chrom` stays stable while `cand_valid` is high and `cand_ready` is low. `fit_ready` stays high until `fit_valid` is seen. The scorer may stall either stream for any number of cycles.

Top module: `evo_search_engine`

## Requirements
- R1: A candidate is transferred when `cand_valid` and `cand_ready` are both high on a clock edge. The engine then raises `fit_ready` and holds it until `fit_valid` is seen. `cand_valid` and `fit_ready` are never high together, and `cand_chrom` stays stable while a candidate waits for `cand_ready`.
- R2: Each generation offers exactly `POP` candidates. With `seed_en` low at `start`, generation zero is filled from the LFSR.
- R3: With `seed_en` high at `start`, slot 0 of generation zero equals `seed_chrom`, and every later slot of generation zero differs from `seed_chrom` in exactly one bit.
- R4: The parents of the next generation are the `NPAR` highest-scoring candidates of the current generation, ranked by score. On equal scores, the lower slot index ranks higher.
- R5: In every generation after the first, slot 0 is an exact copy of the rank-0 parent.
- R6: In every generation after the first, slot k>0 differs from the parent of rank (k mod `NPAR`) in exactly one bit. The flipped bit lies in 0..`CW`-1: LFSR draws of `CW` or above are rejected and drawn again.
- R7: When the best score of a generation is at or above `perfect_fit`, the search stops with cause code 1.
- R8: When `STALL_LIM` consecutive generations pass without the best score rising above the best seen so far, the search stops with cause code 2.
- R9: When `GEN_LIM` generations have run, the search stops with cause code 3. If several conditions hold at the same boundary, code 1 wins over code 2, and code 2 wins over code 3.
- R10: On stopping, `done` is high for exactly one cycle and `busy` falls in the next cycle. `best_fit` and `best_chrom` hold the best score seen and the first chromosome that reached it, and `gen_count` holds the number of generations that ran.
- R11: After reset, `busy`, `done`, `cand_valid` and `fit_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (sampled while idle) |
| seed_en | input | 1 | Build generation zero from `seed_chrom` |
| seed_chrom | input | CW | Seed chromosome |
| perfect_fit | input | FW | Score that ends the search as perfect |
| cand_valid | output | 1 | Candidate chromosome offered |
| cand_ready | input | 1 | Scorer accepts the candidate |
| cand_chrom | output | CW | Candidate chromosome |
| fit_valid | input | 1 | Score present |
| fit_ready | output | 1 | Engine waits for a score |
| fit_score | input | FW | Score of the last candidate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| done_cause | output | 2 | 1 perfect, 2 stagnation, 3 generation limit |
| best_chrom | output | CW | Best chromosome found |
| best_fit | output | FW | Best score found |
| gen_count | output | GW | Generations completed |

## Verification
The main function is tried with four scorers, and each stop condition is reached by its own scorer. A score that rises with every candidate keeps the search improving, so only the generation limit can end it. A constant score makes every generation a tie: this isolates the lowest-index tie rule and ends the search by stagnation. A seed equal to the target of a bit-match scorer ends the search by perfection after one generation and exposes the seeded first generation. A random bit-match hill-climb mixes all of these rules, and the expected parents, elite copies, one-bit mutants and stop cause come from an independent ranking model. Random stalls on both streams check the hold rules.

// File: rtl/evo_pkg.sv
package evo_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_PERFECT = 2'd1,
    CAUSE_STALL   = 2'd2,
    CAUSE_LIMIT   = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BUILD, ST_FILL, ST_DRAW, ST_OFFER, ST_WAIT, ST_GEN_END, ST_FINISH
  } state_e;
endpackage

// File: rtl/evo_lfsr.sv
module evo_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] INIT = 32'h1F2E_3D4C
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  // Galois form, shifting right, advances every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= INIT;
    else        q <= (q >> 1) ^ (q[0] ? TAPS : '0);
  end
endmodule

// File: rtl/evo_rank.sv
module evo_rank #(
  parameter int CW   = 74,
  parameter int FW   = 8,
  parameter int NPAR = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      ins_en,
  input  logic [CW-1:0]             ins_chrom,
  input  logic [FW-1:0]             ins_fit,
  input  logic                      promote,
  output logic [NPAR-1:0][CW-1:0]   cur_chrom,
  output logic [CW-1:0]             top_chrom,
  output logic [FW-1:0]             top_fit
);
  logic [NPAR-1:0][CW-1:0] nxt_chrom;
  logic [NPAR-1:0][FW-1:0] nxt_fit;
  logic [NPAR-1:0]         nxt_vld;
  logic [NPAR-1:0]         beats;

  // strict compare keeps the earlier (lower index) entry on a tie
  always_comb begin
    for (int i = 0; i < NPAR; i++)
      beats[i] = !nxt_vld[i] || (ins_fit > nxt_fit[i]);
  end

  genvar g;
  generate
    for (g = 0; g < NPAR; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          nxt_chrom[g] <= '0;
          nxt_fit[g]   <= '0;
          nxt_vld[g]   <= 1'b0;
          cur_chrom[g] <= '0;
        end else if (clear) begin
          nxt_vld[g]   <= 1'b0;
          cur_chrom[g] <= '0;
        end else if (promote) begin
          cur_chrom[g] <= nxt_chrom[g];
          nxt_vld[g]   <= 1'b0;
        end else if (ins_en && beats[g]) begin
          if (g == 0) begin
            nxt_chrom[g] <= ins_chrom;
            nxt_fit[g]   <= ins_fit;
            nxt_vld[g]   <= 1'b1;
          end else if (beats[(g == 0) ? 0 : g-1]) begin
            nxt_chrom[g] <= nxt_chrom[(g == 0) ? 0 : g-1];
            nxt_fit[g]   <= nxt_fit[(g == 0) ? 0 : g-1];
            nxt_vld[g]   <= nxt_vld[(g == 0) ? 0 : g-1];
          end else begin
            nxt_chrom[g] <= ins_chrom;
            nxt_fit[g]   <= ins_fit;
            nxt_vld[g]   <= 1'b1;
          end
        end
      end
    end
  endgenerate

  assign top_chrom = nxt_chrom[0];
  assign top_fit   = nxt_fit[0];
endmodule

// File: rtl/evo_term.sv
module evo_term
  import evo_pkg::*;
#(
  parameter int FW        = 8,
  parameter int STALL_LIM = 1000,
  parameter int GEN_LIM   = 3000,
  localparam int SW = $clog2(STALL_LIM + 1),
  localparam int GW = $clog2(GEN_LIM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [FW-1:0] gen_best,
  input  logic [FW-1:0] perfect_fit,
  output logic          improve,
  output logic          stop,
  output cause_e        cause,
  output logic [FW-1:0] best_fit,
  output logic [GW-1:0] gen_count
);
  logic          have_best;
  logic [SW-1:0] stall;
  logic [SW-1:0] stall_nx;
  logic [GW-1:0] gen_nx;

  always_comb begin
    improve  = !have_best || (gen_best > best_fit);
    stall_nx = improve ? '0 : stall + 1'b1;
    gen_nx   = gen_count + 1'b1;
    if (gen_best >= perfect_fit)       cause = CAUSE_PERFECT;
    else if (stall_nx == SW'(STALL_LIM)) cause = CAUSE_STALL;
    else if (gen_nx == GW'(GEN_LIM))   cause = CAUSE_LIMIT;
    else                               cause = CAUSE_NONE;
    stop = (cause != CAUSE_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_best <= 1'b0;
      best_fit  <= '0;
      stall     <= '0;
      gen_count <= '0;
    end else if (clear) begin
      have_best <= 1'b0;
      best_fit  <= '0;
      stall     <= '0;
      gen_count <= '0;
    end else if (step) begin
      have_best <= 1'b1;
      if (improve) best_fit <= gen_best;
      stall     <= stall_nx;
      gen_count <= gen_nx;
    end
  end
endmodule

// File: rtl/evo_search_engine.sv
module evo_search_engine
  import evo_pkg::*;
#(
  parameter int          CW        = 74,
  parameter int          FW        = 8,
  parameter int          POP       = 128,
  parameter int          NPAR      = 4,
  parameter int          STALL_LIM = 1000,
  parameter int          GEN_LIM   = 3000,
  parameter logic [31:0] LFSR_INIT = 32'h1F2E_3D4C,
  localparam int GW    = $clog2(GEN_LIM + 1),
  localparam int IW    = $clog2(CW),
  localparam int PW    = $clog2(POP),
  localparam int QW    = (NPAR > 1) ? $clog2(NPAR) : 1,
  localparam int NWORD = (CW + 31) / 32,
  localparam int FCW   = $clog2(NWORD) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          seed_en,
  input  logic [CW-1:0] seed_chrom,
  input  logic [FW-1:0] perfect_fit,
  output logic          cand_valid,
  input  logic          cand_ready,
  output logic [CW-1:0] cand_chrom,
  input  logic          fit_valid,
  output logic          fit_ready,
  input  logic [FW-1:0] fit_score,
  output logic          busy,
  output logic          done,
  output logic [1:0]    done_cause,
  output logic [CW-1:0] best_chrom,
  output logic [FW-1:0] best_fit,
  output logic [GW-1:0] gen_count
);
  state_e                  state;
  logic [PW-1:0]           slot;
  logic [QW-1:0]           par_sel;
  logic [FCW-1:0]          fill_cnt;
  logic [CW-1:0]           cand_q;
  logic [CW-1:0]           base_q;
  logic [CW-1:0]           seed_q;
  logic                    seed_mode_q;
  cause_e                  cause_q;
  logic [CW-1:0]           best_chrom_q;
  logic [31:0]             rnd;
  logic [IW-1:0]           flip_idx;
  logic                    gen_zero;
  logic                    go;
  logic                    ins_en;
  logic                    gen_step;
  logic [NPAR-1:0][CW-1:0] par_chrom;
  logic [CW-1:0]           top_chrom;
  logic [FW-1:0]           top_fit;
  logic                    t_improve;
  logic                    t_stop;
  cause_e                  t_cause;

  evo_lfsr #(.W(32), .TAPS(32'h8020_0003), .INIT(LFSR_INIT)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .q(rnd)
  );

  assign go       = (state == ST_IDLE) && start;
  assign ins_en   = (state == ST_WAIT) && fit_valid;
  assign gen_step = (state == ST_GEN_END);
  assign gen_zero = (gen_count == '0);
  assign flip_idx = rnd[IW-1:0];

  evo_rank #(.CW(CW), .FW(FW), .NPAR(NPAR)) u_rank (
    .clk(clk), .rst_n(rst_n), .clear(go),
    .ins_en(ins_en), .ins_chrom(cand_q), .ins_fit(fit_score),
    .promote(gen_step), .cur_chrom(par_chrom),
    .top_chrom(top_chrom), .top_fit(top_fit)
  );

  evo_term #(.FW(FW), .STALL_LIM(STALL_LIM), .GEN_LIM(GEN_LIM)) u_term (
    .clk(clk), .rst_n(rst_n), .clear(go), .step(gen_step),
    .gen_best(top_fit), .perfect_fit(perfect_fit),
    .improve(t_improve), .stop(t_stop), .cause(t_cause),
    .best_fit(best_fit), .gen_count(gen_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      slot         <= '0;
      par_sel      <= '0;
      fill_cnt     <= '0;
      cand_q       <= '0;
      base_q       <= '0;
      seed_q       <= '0;
      seed_mode_q  <= 1'b0;
      cause_q      <= CAUSE_NONE;
      best_chrom_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          seed_q       <= seed_chrom;
          seed_mode_q  <= seed_en;
          slot         <= '0;
          par_sel      <= '0;
          cause_q      <= CAUSE_NONE;
          best_chrom_q <= '0;
          state        <= ST_BUILD;
        end
        ST_BUILD: begin
          if (gen_zero && !seed_mode_q) begin
            fill_cnt <= '0;
            state    <= ST_FILL;
          end else if (slot == '0) begin
            cand_q <= gen_zero ? seed_q : par_chrom[0];
            state  <= ST_OFFER;
          end else begin
            base_q <= gen_zero ? seed_q : par_chrom[par_sel];
            state  <= ST_DRAW;
          end
        end
        ST_FILL: begin
          cand_q   <= CW'({cand_q, rnd});
          fill_cnt <= fill_cnt + 1'b1;
          if (fill_cnt == FCW'(NWORD - 1)) state <= ST_OFFER;
        end
        ST_DRAW: if (32'(flip_idx) < CW) begin
          cand_q <= base_q ^ (CW'(1) << flip_idx);
          state  <= ST_OFFER;
        end
        ST_OFFER: if (cand_ready) state <= ST_WAIT;
        ST_WAIT: if (fit_valid) begin
          if (slot == PW'(POP - 1)) begin
            state <= ST_GEN_END;
          end else begin
            slot    <= slot + 1'b1;
            par_sel <= (par_sel == QW'(NPAR - 1)) ? '0 : par_sel + 1'b1;
            state   <= ST_BUILD;
          end
        end
        ST_GEN_END: begin
          if (t_improve) best_chrom_q <= top_chrom;
          slot    <= '0;
          par_sel <= '0;
          if (t_stop) begin
            cause_q <= t_cause;
            state   <= ST_FINISH;
          end else begin
            state <= ST_BUILD;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign cand_valid = (state == ST_OFFER);
  assign cand_chrom = cand_q;
  assign fit_ready  = (state == ST_WAIT);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FINISH);
  assign done_cause = cause_q;
  assign best_chrom = best_chrom_q;
endmodule

// File: rtl/evo_search_engine_chk.sv
module evo_search_engine_chk #(
  parameter int CW      = 74,
  parameter int FW      = 8,
  parameter int GEN_LIM = 3000,
  localparam int GW = $clog2(GEN_LIM + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cand_valid,
  input logic          cand_ready,
  input logic [CW-1:0] cand_chrom,
  input logic          fit_valid,
  input logic          fit_ready,
  input logic          busy,
  input logic          done,
  input logic [1:0]    done_cause,
  input logic [FW-1:0] best_fit,
  input logic [GW-1:0] gen_count
);
  p_cand_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_chrom));

  p_one_inflight_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cand_valid && fit_ready));

  p_fit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fit_ready && !fit_valid |=> fit_ready);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  p_cause_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_cause != 2'd0);

  p_best_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> best_fit >= $past(best_fit));

  p_gen_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> gen_count <= GW'(GEN_LIM));
endmodule

bind evo_search_engine evo_search_engine_chk #(.CW(CW), .FW(FW), .GEN_LIM(GEN_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_ready(cand_ready),
  .cand_chrom(cand_chrom), .fit_valid(fit_valid), .fit_ready(fit_ready),
  .busy(busy), .done(done), .done_cause(done_cause), .best_fit(best_fit),
  .gen_count(gen_count)
);

// File: tb/evo_search_engine_bench.sv
module evo_search_engine_bench;
  localparam int CW = 74, FW = 8, POP = 8, NPAR = 4, STALL = 5, GLIM = 12;
  localparam int GW = $clog2(GLIM + 1);

  logic          clk = 0, rst_n = 0, start = 0, seed_en = 0;
  logic [CW-1:0] seed_chrom = '0;
  logic [FW-1:0] perfect_fit = '0;
  logic          cand_valid, cand_ready = 0, fit_valid = 0, fit_ready;
  logic [CW-1:0] cand_chrom, best_chrom;
  logic [FW-1:0] fit_score = '0, best_fit;
  logic          busy, done;
  logic [1:0]    done_cause;
  logic [GW-1:0] gen_count;

  always #4 clk = ~clk;

  evo_search_engine #(.CW(CW), .FW(FW), .POP(POP), .NPAR(NPAR),
                      .STALL_LIM(STALL), .GEN_LIM(GLIM)) u_evo_search_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_en(seed_en),
    .seed_chrom(seed_chrom), .perfect_fit(perfect_fit),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_chrom(cand_chrom),
    .fit_valid(fit_valid), .fit_ready(fit_ready), .fit_score(fit_score),
    .busy(busy), .done(done), .done_cause(done_cause), .best_chrom(best_chrom),
    .best_fit(best_fit), .gen_count(gen_count)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard items: 0 any, 1 exact copy, 2 one-bit mutant
  typedef struct { int kind; logic [CW-1:0] ref_c; string req; } exp_t;
  exp_t sb[$];

  logic [CW-1:0] g_chrom [POP];
  int            g_score [POP];
  logic [CW-1:0] m_par   [NPAR];
  int m_best, m_stall, m_gens, m_cause;
  bit m_have;
  logic [CW-1:0] m_best_chrom;

  // driver: queue the expected relation of every slot of the next generation
  task automatic push_gen(input bit first, input bit sm, input logic [CW-1:0] sd);
    exp_t e;
    for (int s = 0; s < POP; s++) begin
      if (first && !sm) begin e.kind = 0; e.ref_c = '0; e.req = "R2"; end
      else if (first) begin
        e.ref_c = sd; e.kind = (s == 0) ? 1 : 2; e.req = "R3";
      end else if (s == 0) begin
        e.kind = 1; e.ref_c = m_par[0]; e.req = "R5";
      end else begin
        e.kind = 2; e.ref_c = m_par[s % NPAR]; e.req = "R6";
      end
      sb.push_back(e);
    end
  endtask

  // model of ranking (R4) and stop rules (R7, R8, R9)
  task automatic gen_end(input int pf);
    bit taken [POP];
    int gb;
    bit imp;
    for (int s = 0; s < POP; s++) taken[s] = 0;
    for (int p = 0; p < NPAR; p++) begin
      int bi = -1;
      for (int s = 0; s < POP; s++)
        if (!taken[s] && (bi < 0 || g_score[s] > g_score[bi])) bi = s;
      taken[bi] = 1;
      m_par[p] = g_chrom[bi];
      if (p == 0) gb = g_score[bi];
    end
    imp = !m_have || gb > m_best;
    if (imp) begin m_best = gb; m_best_chrom = m_par[0]; end
    m_have = 1;
    m_stall = imp ? 0 : m_stall + 1;
    m_gens++;
    if (gb >= pf) m_cause = 1;
    else if (m_stall == STALL) m_cause = 2;
    else if (m_gens == GLIM) m_cause = 3;
    else m_cause = 0;
  endtask

  task automatic run(input bit sm, input logic [CW-1:0] sd, input int mode,
                     input logic [CW-1:0] tgt, input int pf,
                     input int x_cause, input int x_gens, input int x_best);
    int cyc = 0, gi = 0, seq = 0, cur = 0;
    bit owed = 0;
    exp_t e;
    m_have = 0; m_best = 0; m_stall = 0; m_gens = 0; m_cause = 0;
    m_best_chrom = '0;
    sb.delete();
    @(negedge clk);
    seed_en = sm; seed_chrom = sd; perfect_fit = FW'(pf); start = 1;
    @(negedge clk);
    start = 0;
    push_gen(1, sm, sd);
    forever begin
      @(negedge clk);
      cyc++;
      cand_ready = 0; fit_valid = 0;
      if (done) begin
        chk(m_cause != 0, "R10 done only when model stops", 0, 0);
        chk(done_cause == 2'(m_cause), "R7/R8/R9 cause", CW'(done_cause), CW'(m_cause));
        if (x_cause >= 0)
          chk(done_cause == 2'(x_cause), "R9 fixed cause", CW'(done_cause), CW'(x_cause));
        chk(gen_count == GW'(m_gens), "R10 gen_count", CW'(gen_count), CW'(m_gens));
        if (x_gens >= 0)
          chk(gen_count == GW'(x_gens), "R10 fixed gens", CW'(gen_count), CW'(x_gens));
        chk(best_fit == FW'(m_best), "R10 best_fit", CW'(best_fit), CW'(m_best));
        if (x_best >= 0)
          chk(best_fit == FW'(x_best), "R10 fixed best", CW'(best_fit), CW'(x_best));
        chk(best_chrom == m_best_chrom, "R10 best_chrom", best_chrom, m_best_chrom);
        chk(sb.size() == 0, "R2 all slots offered", CW'(sb.size()), 0);
        @(negedge clk);
        chk(!done && !busy, "R10 one-cycle done", CW'({done, busy}), 0);
        break;
      end
      if (cyc > 20000) begin
        chk(0, "watchdog", CW'(cyc), 0);
        break;
      end
      if (cand_valid && $urandom_range(0, 2) != 0) begin
        cand_ready = 1;
        if (sb.size() == 0) begin
          chk(0, "R2 extra candidate", cand_chrom, 0);
        end else begin
          e = sb.pop_front();
          if (e.kind == 1) chk(cand_chrom == e.ref_c, e.req, cand_chrom, e.ref_c);
          else if (e.kind == 2)
            chk($countones(cand_chrom ^ e.ref_c) == 1, e.req, cand_chrom, e.ref_c);
        end
        seq++;
        g_chrom[gi] = cand_chrom;
        case (mode)
          0: cur = CW - $countones(cand_chrom ^ tgt);
          1: cur = 5;
          default: cur = seq;
        endcase
        owed = 1;
      end
      if (fit_ready && owed && $urandom_range(0, 2) != 0) begin
        fit_valid = 1;
        fit_score = FW'(cur);
        owed = 0;
        g_score[gi] = cur;
        gi++;
        if (gi == POP) begin
          gi = 0;
          gen_end(pf);
          if (m_cause == 0) push_gen(0, sm, sd);
        end
      end
    end
    cand_ready = 0; fit_valid = 0;
  endtask

  logic [CW-1:0] sd_c, tg_d;

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cand_valid && !fit_ready, "R11 reset state",
        CW'({busy, done, cand_valid, fit_ready}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !cand_valid, "R11 idle after reset", CW'({busy, cand_valid}), 0);
    // rising scores: only the generation limit stops it (R9, R4, R5, R6)
    run(0, '0, 2, '0, 255, 3, GLIM, POP * GLIM);
    // constant scores: ties, stagnation (R8, R4)
    run(0, '0, 1, '0, 255, 2, STALL + 1, 5);
    // seeded start equal to target: perfect after one generation (R3, R7)
    sd_c = {10'h2A5, 32'hDEAD_BEEF, 32'h0123_4567};
    run(1, sd_c, 0, sd_c, CW, 1, 1, CW);
    chk(best_chrom == sd_c, "R7 perfect chromosome is seed", best_chrom, sd_c);
    // seeded hill-climb toward another target, model decides the stop
    tg_d = {10'h155, 32'hCAFE_F00D, 32'h8765_4321};
    run(1, sd_c, 0, tg_d, CW, -1, -1, -1);
    // random start hill-climb
    run(0, '0, 0, tg_d, CW, -1, -1, -1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule